// File: doc/BRIEF.md
# Transducer Status and Interrupt Mask Aggregator

This block keeps the event status of a transducer module and turns it into one active-low service-request line. It has one global register set and one set for each of `NUM_CH` channels. Each set holds four 16-bit words: a standard status word and its interrupt mask, and an auxiliary status word and its auxiliary mask. Local logic reports events on per-set event buses. Each asserted event bit sets the matching status bit, and that bit stays set until a host reads it.

A host reaches the registers through a parallel byte port. Every access moves one 16-bit word as two byte strobes, high byte first. A channel number of 0 selects the global set and 1..`NUM_CH` select a channel. A selector picks the word, and there is also a trigger-channel address register. Reading a status word clears the bits that were returned. The global word is the exception: its operational bit stays set. An interrupt can come from any channel's own summary, from the global summary, or from any auxiliary word seen through its auxiliary mask.

Top module: `stim_status_agg`

## Requirements
- R1: After reset every standard mask reads 0xFFFE, every auxiliary mask reads 0x0000, channel status and all auxiliary status read 0x0000, global status reads 0x0100 (bit 8 = operational), the trigger address reads 0 and `irq_n` is high.
- R2: `bus_chan` 0 addresses the global set and 1..NUM_CH address the channel sets. For a larger channel number, reads of status and mask words return 0x0000 and writes change nothing.
- R3: A word moves as two strobes, high byte first. `bus_sel` encodes 0 status, 1 mask, 2 auxiliary status, 3 auxiliary mask, 4 trigger address. A mask write takes effect only on the low-byte strobe.
- R4: An event bit sets the matching status bit by OR. Events cannot set status bit 0 (summary) or bit 7 (auxiliary present), nor bit 8 of the global word.
- R5: After the low byte of a status read, the bits that were returned are cleared. For global status, bit 8 stays set, so its high byte reads 0x01.
- R6: An event that arrives in the same cycle as the low-byte strobe of a status read stays set.
- R7: Status bit 0 reads 1 when (status AND mask) has any bit set among bits 15..1. For the global word, bit 8 is left out of this test.
- R8: `irq_n` goes low one clock after any set's summary is 1 or any set's (auxiliary status AND auxiliary mask) is nonzero. It goes high one clock after none holds.
- R9: Status bit 7 reads 1 whenever the set's auxiliary status is nonzero. Through mask bit 7 it feeds the summary even when the auxiliary mask is 0.
- R10: A trigger address write with a value of at most NUM_CH updates `trig_chan`. A larger value leaves it unchanged and sets global status bit 1 (invalid command).
- R11: `bus_abort` discards a half-written word. The next strobe is taken as a high byte.
- R12: Reading an auxiliary status word clears the bits it returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_stb | input | 1 | Byte strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Word selector |
| bus_chan | input | CH_W | Channel number, 0 = global |
| bus_wbyte | input | 8 | Write byte |
| bus_abort | input | 1 | Discard a partial word |
| bus_rbyte | output | 8 | Read byte, valid the cycle after its strobe |
| ev_global | input | 16 | Global status events |
| ev_global_aux | input | 16 | Global auxiliary events |
| ev_chan | input | 16*NUM_CH | Channel status events, channel 1 in the low slice |
| ev_chan_aux | input | 16*NUM_CH | Channel auxiliary events |
| trig_chan | output | CH_W | Accepted trigger channel address |
| irq_n | output | 1 | Registered active-low service request |

## Verification
The assertions take for granted that `bus_sel`, `bus_chan` and `bus_wr` stay steady across both strobes of a word. They also assume that no global event arrives in the cycle of a global low-byte status read. The bench holds the selector fields fixed through each word and moves them only between words. It drives events only outside the read strobes, except in the one test that places an event on the low-byte strobe of a channel read on purpose.

// File: rtl/stim_agg_pkg.sv
`timescale 1ns/1ps
// Shared selector encoding, bit positions and reset values for the aggregator.
package stim_agg_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SEL_STAT    = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_AUX     = 3'd2,
        SEL_AUXMASK = 3'd3,
        SEL_TRIG    = 3'd4
    } sel_e;

    localparam int BIT_SRQ   = 0;
    localparam int BIT_INVAL = 1;
    localparam int BIT_AUX   = 7;
    localparam int BIT_OPER  = 8;

    localparam logic [WORD_W-1:0] STD_MASK_RST = 16'hFFFE;
    localparam logic [WORD_W-1:0] AUX_MASK_RST = 16'h0000;
endpackage

// File: rtl/stim_byte_seq.sv
`timescale 1ns/1ps
// Byte sequencer: tracks the high/low phase of a 16-bit transfer, holds the
// written high byte, and snapshots the addressed word at the high-byte strobe
// so both read bytes come from one value. Abort returns it to the high phase.
// Assumes the selector and channel stay steady across both strobes of a word.
module stim_byte_seq
    import stim_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              abort,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [WORD_W-1:0] cur_word,
    output logic              phase_q,
    output logic [WORD_W-1:0] snap_q,
    output logic [WORD_W-1:0] wr_word,
    output logic              word_done,
    output logic [BYTE_W-1:0] rbyte_q
);
    logic [BYTE_W-1:0] hi_q;

    // A word completes on a low-phase strobe that is not aborted.
    assign word_done = stb & phase_q & ~abort;
    assign wr_word   = {hi_q, wbyte};

    // Phase, held write byte, read snapshot and read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            hi_q    <= '0;
            snap_q  <= '0;
            rbyte_q <= '0;
        end else if (abort) begin
            phase_q <= 1'b0;
        end else if (stb) begin
            phase_q <= ~phase_q;
            if (!phase_q) begin
                hi_q    <= wbyte;
                snap_q  <= cur_word;
                rbyte_q <= cur_word[WORD_W-1:BYTE_W];
            end else begin
                rbyte_q <= snap_q[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/stim_regset.sv
`timescale 1ns/1ps
// One register set: standard status, mask, auxiliary status, auxiliary mask.
// Events set status bits; a read clears the returned bits, and an event in the
// same cycle wins. Bits 0 (summary) and 7 (auxiliary present) are derived.
// The global variant keeps bit 8 (operational) set and leaves it out of the
// summary.
module stim_regset
    import stim_agg_pkg::*;
#(
    parameter bit IS_GLOBAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ev_std,
    input  logic [WORD_W-1:0] ev_aux,
    input  logic              clr_std,
    input  logic              clr_aux,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic              mask_we,
    input  logic              amask_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] std_view,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] aux_q,
    output logic [WORD_W-1:0] amask_q,
    output logic              srq,
    output logic              aux_hit
);
    localparam logic [WORD_W-1:0] DERIVED  = (WORD_W'(1) << BIT_SRQ) | (WORD_W'(1) << BIT_AUX);
    localparam logic [WORD_W-1:0] KEEP     = IS_GLOBAL ? (WORD_W'(1) << BIT_OPER) : '0;
    localparam logic [WORD_W-1:0] EV_OK    = ~DERIVED & ~KEEP;
    localparam logic [WORD_W-1:0] SUM_BITS = ~(WORD_W'(1) << BIT_SRQ) & ~KEEP;

    logic [WORD_W-1:0] std_q;
    logic [WORD_W-1:0] base;

    // Summary and auxiliary-present bits computed from the stored words.
    always_comb begin
        base          = std_q;
        base[BIT_AUX] = |aux_q;
        srq           = |(base & mask_q & SUM_BITS);
        std_view      = base;
        std_view[BIT_SRQ] = srq;
        aux_hit       = |(aux_q & amask_q);
    end

    // Standard status: OR in events, clear read bits, restore kept bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            std_q <= KEEP;
        else if (clr_std)
            std_q <= (std_q & ~clr_bits) | KEEP | (ev_std & EV_OK);
        else
            std_q <= std_q | (ev_std & EV_OK);
    end

    // Auxiliary status: all bits event driven, cleared by its own read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aux_q <= '0;
        else if (clr_aux)
            aux_q <= (aux_q & ~clr_bits) | ev_aux;
        else
            aux_q <= aux_q | ev_aux;
    end

    // Mask registers, loaded on a completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= STD_MASK_RST;
            amask_q <= AUX_MASK_RST;
        end else begin
            if (mask_we)  mask_q  <= wdata;
            if (amask_we) amask_q <= wdata;
        end
    end
endmodule

// File: rtl/stim_status_agg.sv
`timescale 1ns/1ps
// Status and interrupt mask aggregator: a global register set plus NUM_CH
// channel sets behind a two-strobe byte port, a range-checked trigger
// address register, and a registered active-low interrupt.
module stim_status_agg
    import stim_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_stb,
    input  logic                     bus_wr,
    input  logic [2:0]               bus_sel,
    input  logic [CH_W-1:0]          bus_chan,
    input  logic [BYTE_W-1:0]        bus_wbyte,
    input  logic                     bus_abort,
    output logic [BYTE_W-1:0]        bus_rbyte,
    input  logic [WORD_W-1:0]        ev_global,
    input  logic [WORD_W-1:0]        ev_global_aux,
    input  logic [NUM_CH*WORD_W-1:0] ev_chan,
    input  logic [NUM_CH*WORD_W-1:0] ev_chan_aux,
    output logic [CH_W-1:0]          trig_chan,
    output logic                     irq_n
);
    localparam int NSET = NUM_CH + 1;

    logic [NSET-1:0][WORD_W-1:0] view_w, mask_w, aux_w, amask_w, ev_std, ev_aux;
    logic [NSET-1:0]             srq_w, ahit_w, clr_std, clr_aux, mask_we, amask_we;
    logic [WORD_W-1:0]           cur_word, snap_q, wr_word, inval_ev;
    logic                        phase_q, word_done, trig_we, trig_bad;
    logic [CH_W-1:0]             trig_q;

    stim_byte_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bus_stb),
        .abort     (bus_abort),
        .wbyte     (bus_wbyte),
        .cur_word  (cur_word),
        .phase_q   (phase_q),
        .snap_q    (snap_q),
        .wr_word   (wr_word),
        .word_done (word_done),
        .rbyte_q   (bus_rbyte)
    );

    // Trigger address write decode and range check.
    assign trig_we  = word_done & bus_wr & (bus_sel == SEL_TRIG);
    assign trig_bad = trig_we & (wr_word > WORD_W'(NUM_CH));
    assign inval_ev = WORD_W'(trig_bad) << BIT_INVAL;

    for (genvar g = 0; g < NSET; g++) begin : g_set
        localparam logic [CH_W-1:0] MY_CH = CH_W'(g);
        logic hit;
        assign hit = (bus_chan == MY_CH);

        if (g == 0) begin : g_glb
            assign ev_std[g] = ev_global | inval_ev;
            assign ev_aux[g] = ev_global_aux;
        end else begin : g_ch
            assign ev_std[g] = ev_chan[(g-1)*WORD_W +: WORD_W];
            assign ev_aux[g] = ev_chan_aux[(g-1)*WORD_W +: WORD_W];
        end

        assign clr_std[g]  = word_done & ~bus_wr & hit & (bus_sel == SEL_STAT);
        assign clr_aux[g]  = word_done & ~bus_wr & hit & (bus_sel == SEL_AUX);
        assign mask_we[g]  = word_done &  bus_wr & hit & (bus_sel == SEL_MASK);
        assign amask_we[g] = word_done &  bus_wr & hit & (bus_sel == SEL_AUXMASK);

        stim_regset #(.IS_GLOBAL(g == 0)) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_std   (ev_std[g]),
            .ev_aux   (ev_aux[g]),
            .clr_std  (clr_std[g]),
            .clr_aux  (clr_aux[g]),
            .clr_bits (snap_q),
            .mask_we  (mask_we[g]),
            .amask_we (amask_we[g]),
            .wdata    (wr_word),
            .std_view (view_w[g]),
            .mask_q   (mask_w[g]),
            .aux_q    (aux_w[g]),
            .amask_q  (amask_w[g]),
            .srq      (srq_w[g]),
            .aux_hit  (ahit_w[g])
        );
    end

    // Read word select; unknown channel numbers and selectors read zero.
    always_comb begin
        cur_word = '0;
        if (bus_sel == SEL_TRIG) begin
            cur_word = WORD_W'(trig_q);
        end else begin
            for (int i = 0; i < NSET; i++) begin
                if (bus_chan == CH_W'(i)) begin
                    case (bus_sel)
                        SEL_STAT:    cur_word = view_w[i];
                        SEL_MASK:    cur_word = mask_w[i];
                        SEL_AUX:     cur_word = aux_w[i];
                        SEL_AUXMASK: cur_word = amask_w[i];
                        default:     cur_word = '0;
                    endcase
                end
            end
        end
    end

    // Trigger address register: accept in-range values only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else if (trig_we && !trig_bad)
            trig_q <= wr_word[CH_W-1:0];
    end
    assign trig_chan = trig_q;

    // Registered service request over both summary and auxiliary paths.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~(|srq_w | |ahit_w);
    end
endmodule

// File: rtl/stim_status_agg_chk.sv
`timescale 1ns/1ps
// Checker bound into the aggregator. Assumes selector and channel are steady
// across a word and no global event lands on a global low-byte status read.
module stim_status_agg_chk
    import stim_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_stb,
    input logic                            bus_wr,
    input logic [2:0]                      bus_sel,
    input logic [CH_W-1:0]                 bus_chan,
    input logic                            bus_abort,
    input logic [WORD_W-1:0]               ev_global,
    input logic                            phase_q,
    input logic [WORD_W-1:0]               wr_word,
    input logic [CH_W-1:0]                 trig_chan,
    input logic [WORD_W-1:0]               gview,
    input logic                            gsrq,
    input logic [NUM_CH:0][WORD_W-1:0]     mask_all,
    input logic                            irq_n
);
    p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> irq_n);

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_wr && !phase_q) |=> $stable(mask_all));

    p_oper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gview[BIT_OPER]);

    p_gread_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_wr && phase_q && !bus_abort && bus_sel == SEL_STAT &&
         bus_chan == '0 && ev_global == '0) |=> (gview[15:9] == '0));

    p_gsrq_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gsrq |=> !irq_n);

    p_trig_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_chan <= CH_W'(NUM_CH));

    p_trig_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_wr && phase_q && !bus_abort && bus_sel == SEL_TRIG &&
         wr_word > WORD_W'(NUM_CH)) |=> ($stable(trig_chan) && gview[BIT_INVAL]));

    p_abort_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |=> !phase_q);
endmodule

bind stim_status_agg stim_status_agg_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_stb   (bus_stb),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_chan  (bus_chan),
    .bus_abort (bus_abort),
    .ev_global (ev_global),
    .phase_q   (phase_q),
    .wr_word   (wr_word),
    .trig_chan (trig_chan),
    .gview     (view_w[0]),
    .gsrq      (srq_w[0]),
    .mask_all  (mask_w),
    .irq_n     (irq_n)
);

// File: tb/test_stim_status_agg.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of word accesses, then directed tests.
module test_stim_status_agg;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_stb = 1'b0, bus_wr = 1'b0, bus_abort = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [7:0] bus_chan = '0, bus_wbyte = '0;
    logic [7:0] bus_rbyte;
    logic [15:0] ev_global = '0, ev_global_aux = '0;
    logic [NCH*16-1:0] ev_chan = '0, ev_chan_aux = '0;
    logic [7:0] trig_chan;
    logic irq_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stim_status_agg #(.NUM_CH(NCH), .CH_W(8)) i_stim_status_agg (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_chan(bus_chan), .bus_wbyte(bus_wbyte),
        .bus_abort(bus_abort), .bus_rbyte(bus_rbyte), .ev_global(ev_global),
        .ev_global_aux(ev_global_aux), .ev_chan(ev_chan), .ev_chan_aux(ev_chan_aux),
        .trig_chan(trig_chan), .irq_n(irq_n));

    localparam logic [2:0] S_ST = 3'd0, S_MK = 3'd1, S_AX = 3'd2, S_AM = 3'd3, S_TR = 3'd4;

    // {write, sel, chan, data, expected}
    localparam int NVEC = 15;
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b1, S_MK, 8'd1, 16'h00F0, 16'h0000},   // R3 mask write
        {1'b0, S_MK, 8'd1, 16'h0000, 16'h00F0},   // R3
        {1'b1, S_AM, 8'd0, 16'h8001, 16'h0000},   // R2 global aux mask
        {1'b0, S_AM, 8'd0, 16'h0000, 16'h8001},   // R2
        {1'b1, S_MK, 8'd5, 16'h1234, 16'h0000},   // R2 out of range write
        {1'b0, S_MK, 8'd5, 16'h0000, 16'h0000},   // R2 out of range read
        {1'b0, S_MK, 8'd4, 16'h0000, 16'hFFFE},   // R2 no aliasing
        {1'b1, S_TR, 8'd0, 16'h0003, 16'h0000},   // R10 valid
        {1'b0, S_TR, 8'd0, 16'h0000, 16'h0003},   // R10
        {1'b1, S_TR, 8'd0, 16'h0009, 16'h0000},   // R10 rejected
        {1'b0, S_TR, 8'd0, 16'h0000, 16'h0003},   // R10 kept
        {1'b0, S_ST, 8'd0, 16'h0000, 16'h0103},   // R10 invalid bit, R7 summary
        {1'b0, S_ST, 8'd0, 16'h0000, 16'h0100},   // R5 cleared, oper kept
        {1'b1, S_MK, 8'd1, 16'hFFFE, 16'h0000},
        {1'b1, S_AM, 8'd0, 16'h0000, 16'h0000}
    };

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd16(input logic [2:0] sel, input logic [7:0] ch, output logic [15:0] v);
        bus_stb = 1'b1; bus_wr = 1'b0; bus_sel = sel; bus_chan = ch;
        tick(); v[15:8] = bus_rbyte;
        tick(); v[7:0] = bus_rbyte;
        bus_stb = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] sel, input logic [7:0] ch, input logic [15:0] d);
        bus_stb = 1'b1; bus_wr = 1'b1; bus_sel = sel; bus_chan = ch;
        bus_wbyte = d[15:8]; tick();
        bus_wbyte = d[7:0];  tick();
        bus_stb = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic ev_pulse(input int ch, input logic [15:0] s, input logic [15:0] a);
        if (ch == 0) begin ev_global = s; ev_global_aux = a; end
        else begin ev_chan[(ch-1)*16 +: 16] = s; ev_chan_aux[(ch-1)*16 +: 16] = a; end
        tick();
        ev_global = '0; ev_global_aux = '0; ev_chan = '0; ev_chan_aux = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 irq_n", {15'b0, irq_n}, 16'h0001);
        rd16(S_MK, 8'd0, v); chk("R1 global mask", v, 16'hFFFE);
        rd16(S_MK, 8'd3, v); chk("R1 ch3 mask", v, 16'hFFFE);
        rd16(S_AM, 8'd2, v); chk("R1 ch2 aux mask", v, 16'h0000);
        rd16(S_ST, 8'd0, v); chk("R1 global status", v, 16'h0100);
        rd16(S_TR, 8'd0, v); chk("R1 trigger addr", v, 16'h0000);

        // Table walk (R2 R3 R5 R7 R10)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][43]) wr16(VEC[i][42:40], VEC[i][39:32], VEC[i][31:16]);
            else begin
                rd16(VEC[i][42:40], VEC[i][39:32], v);
                chk($sformatf("table %0d (R2 R3 R5 R10)", i), v, VEC[i][15:0]);
            end
        end
        chk("R10 trig_chan port", {8'b0, trig_chan}, 16'h0003);
        tick();
        chk("R8 irq released after global read", {15'b0, irq_n}, 16'h0001);

        // R4 R7 R8 channel event path
        ev_pulse(2, 16'h0010, 16'h0); tick();
        chk("R8 irq low on ch2 event", {15'b0, irq_n}, 16'h0000);
        rd16(S_ST, 8'd2, v); chk("R7 ch2 status with summary", v, 16'h0011);
        tick();
        chk("R8 irq high after clear", {15'b0, irq_n}, 16'h0001);
        rd16(S_ST, 8'd2, v); chk("R5 ch2 cleared", v, 16'h0000);
        ev_pulse(3, 16'h0081, 16'h0); tick();
        chk("R4 derived bits not settable irq", {15'b0, irq_n}, 16'h0001);
        rd16(S_ST, 8'd3, v); chk("R4 derived bits not settable", v, 16'h0000);

        // R9 R12 auxiliary bit through channel mask
        ev_pulse(1, 16'h0, 16'h0004); tick();
        chk("R9 irq via aux bit", {15'b0, irq_n}, 16'h0000);
        rd16(S_ST, 8'd1, v); chk("R9 ch1 status aux bit", v, 16'h0081);
        rd16(S_AX, 8'd1, v); chk("R12 ch1 aux read", v, 16'h0004);
        rd16(S_AX, 8'd1, v); chk("R12 ch1 aux cleared", v, 16'h0000);
        rd16(S_ST, 8'd1, v); chk("R9 ch1 status after aux clear", v, 16'h0000);
        tick();
        chk("R9 irq released", {15'b0, irq_n}, 16'h0001);

        // R8 direct auxiliary path, R9 blocked by mask 0
        wr16(S_MK, 8'd3, 16'h0000);
        wr16(S_AM, 8'd3, 16'h0002);
        ev_pulse(3, 16'h0, 16'h0002); tick();
        chk("R8 irq via aux mask", {15'b0, irq_n}, 16'h0000);
        rd16(S_AX, 8'd3, v); chk("R12 ch3 aux", v, 16'h0002);
        tick();
        chk("R8 irq released aux", {15'b0, irq_n}, 16'h0001);
        ev_pulse(3, 16'h0, 16'h0004); tick();
        chk("R8 unmasked aux no irq", {15'b0, irq_n}, 16'h0001);
        rd16(S_ST, 8'd3, v); chk("R9 aux bit without summary", v, 16'h0080);
        rd16(S_AX, 8'd3, v); chk("R12 ch3 aux second", v, 16'h0004);
        wr16(S_MK, 8'd3, 16'hFFFE);
        wr16(S_AM, 8'd3, 16'h0000);

        // R6 event on the clearing strobe wins
        ev_pulse(4, 16'h0020, 16'h0);
        bus_stb = 1'b1; bus_wr = 1'b0; bus_sel = S_ST; bus_chan = 8'd4;
        tick(); v[15:8] = bus_rbyte;
        ev_chan[3*16 +: 16] = 16'h0060;
        tick(); v[7:0] = bus_rbyte;
        bus_stb = 1'b0; ev_chan = '0;
        chk("R6 first read", v, 16'h0021);
        rd16(S_ST, 8'd4, v); chk("R6 coincident set kept", v, 16'h0061);
        rd16(S_ST, 8'd4, v); chk("R5 ch4 cleared", v, 16'h0000);

        // R11 abort discards half-written mask
        bus_stb = 1'b1; bus_wr = 1'b1; bus_sel = S_MK; bus_chan = 8'd2; bus_wbyte = 8'hAB;
        tick();
        bus_stb = 1'b0; bus_abort = 1'b1;
        tick();
        bus_abort = 1'b0; bus_wr = 1'b0;
        wr16(S_MK, 8'd2, 16'h000F);
        rd16(S_MK, 8'd2, v); chk("R11 abort realigns", v, 16'h000F);
        wr16(S_MK, 8'd2, 16'hFFFE);

        // R5 global high byte keeps operational bit
        ev_pulse(0, 16'h8400, 16'h0); tick();
        chk("R8 irq global summary", {15'b0, irq_n}, 16'h0000);
        rd16(S_ST, 8'd0, v); chk("R5 global read", v, 16'h8501);
        rd16(S_ST, 8'd0, v); chk("R5 global high byte 0x01", v, 16'h0100);

        // R1 reset again mid-run
        wr16(S_MK, 8'd1, 16'h1111);
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        rd16(S_MK, 8'd1, v); chk("R1 mask after reset", v, 16'hFFFE);
        chk("R1 trig after reset", {8'b0, trig_chan}, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule